// File: doc/BRIEF.md
# Two-Way Write-Through Data Cache with Store Queue

This block is a small data cache that sits between a processor's load/store port and a slower word-addressed memory. Each access carries a word address. The low address bits pick one set. The two tags of that set are compared side by side, and a two-input mux picks the matching way's word. Reads that hit complete in the cycle the request is presented. A read miss fetches the word from memory, installs it in the least recently used way of the set, and then completes as a hit.

Every store is write-through. The word is written into the cache when the line is present, and it is always pushed into a small first-in first-out store queue. The memory side drains that queue on its own. A store that misses does not allocate a line. When the queue is full, a store waits until memory frees a slot. Before a read miss asks memory for data, the queue is emptied, so the fetched word already includes every earlier store.

The requester raises `cpu_req` with the command, address and write data. It holds them until the cycle in which `cpu_done` is high, and the access completes at the clock edge that ends that cycle.

Top module: `wtc_cache2w`

## Requirements
- R1: After reset every line is invalid, so the first read of any address issues a memory read, and `cpu_done`, `mem_rd_req` and `mem_wr_req` are all low.
- R2: The set index is `cpu_addr[IDX_W-1:0]` and the tag is the remaining upper bits. A read whose tag matches a valid line in either way of its set completes in the request cycle with that line's word and without any memory read.
- R3: On a read miss the block holds `mem_rd_req` high with `mem_rd_addr` equal to `cpu_addr` until `mem_rd_valid`. It then stores `mem_rd_data`, and the read completes with that word.
- R4: On reset, the replacement bit of each set selects way 0. Every hit, whether read or store, and every refill marks the way it used as most recent. A read miss replaces the way that was not used most recently.
- R5: Every accepted store appears on the memory write port exactly once, in acceptance order, with its address and data, whether it hit or missed.
- R6: A store that hits updates the cached word, and a later read of that address hits and returns the new value.
- R7: A store that misses does not allocate a line: a later read of that address misses and fetches the stored value from memory.
- R8: The store queue holds WB_DEPTH entries (4 by default). A store that arrives while the queue is full gets no `cpu_done` until the memory side has taken an entry.
- R9: `mem_rd_req` is never high while the store queue holds an entry. A read miss waits for the queue to empty and then returns data that includes all earlier stores.
- R10: `cpu_done` is high only while `cpu_req` is high, and for a read only when the lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until done |
| cpu_we | input | 1 | 1 = store, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` on a read |
| cpu_done | output | 1 | Access completes at the end of this cycle |
| mem_rd_req | output | 1 | Refill request to memory |
| mem_rd_addr | output | ADDR_W | Refill word address |
| mem_rd_valid | input | 1 | Refill data present for one cycle |
| mem_rd_data | input | DATA_W | Refill data |
| mem_wr_req | output | 1 | Store queue head is valid |
| mem_wr_addr | output | ADDR_W | Head store address |
| mem_wr_data | output | DATA_W | Head store data |
| mem_wr_ack | input | 1 | Memory takes the head entry at this edge |

## Verification
The bench builds the cache with a 6-bit address, 4 sets of 2 ways, 4-bit tags and a 4-entry store queue. At that size a 64-word memory model covers the whole address space, and a sequential sweep overfills every set many times. A small bench-side model of the tags and replacement bits predicts whether each access should hit or miss, and this is checked through the presence of a memory read. Holding off store acknowledgements fills the queue and also holds back a pending read miss, which makes the stall of R8 and the ordering of R9 observable at the ports.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   typedef enum logic [1:0] {
      CTL_IDLE  = 2'd0,
      CTL_DRAIN = 2'd1,
      CTL_FILL  = 2'd2
   } wtc_ctl_t;

   localparam int unsigned WTC_WAYS = 2;
endpackage

// File: rtl/wtc_way.sv
module wtc_way #(
   parameter int unsigned IDX_W  = 6,
   parameter int unsigned TAG_W  = 10,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   input  logic [TAG_W-1:0]  tag,
   output logic              hit,
   output logic [DATA_W-1:0] rd_data,
   input  logic              upd_en,
   input  logic [DATA_W-1:0] upd_data,
   input  logic              fill_en,
   input  logic [DATA_W-1:0] fill_data
);
   localparam int unsigned SETS = 1 << IDX_W;

   logic [SETS-1:0]   vld_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [DATA_W-1:0] word_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (fill_en) begin
         vld_q[idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[idx]  <= tag;
         word_q[idx] <= fill_data;
      end else if (upd_en) begin
         word_q[idx] <= upd_data;
      end
   end

   assign hit     = vld_q[idx] && (tag_q[idx] == tag);
   assign rd_data = word_q[idx];
endmodule

// File: rtl/wtc_lru.sv
module wtc_lru #(
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             touch_en,
   input  logic             touch_way,
   output logic             victim
);
   localparam int unsigned SETS = 1 << IDX_W;

   logic [SETS-1:0] old_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         old_q <= '0;
      end else if (touch_en) begin
         old_q[idx] <= ~touch_way;
      end
   end

   assign victim = old_q[idx];
endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
   parameter int unsigned AW    = 16,
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [AW-1:0]    push_addr,
   input  logic [DW-1:0]    push_data,
   output logic             full,
   output logic             busy,
   output logic [AW-1:0]    head_addr,
   output logic [DW-1:0]    head_data,
   input  logic             pop,
   output logic [CNT_W-1:0] fill_cnt
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   logic [AW-1:0]    addr_q [DEPTH];
   logic [DW-1:0]    data_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] cnt_q;
   logic             do_push, do_pop;

   assign full    = (cnt_q == CNT_FULL);
   assign busy    = (cnt_q != '0);
   assign do_push = push && !full;
   assign do_pop  = pop && busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         addr_q[wr_ptr] <= push_addr;
         data_q[wr_ptr] <= push_data;
      end
   end

   assign head_addr = addr_q[rd_ptr];
   assign head_data = data_q[rd_ptr];
   assign fill_cnt  = cnt_q;
endmodule

// File: rtl/wtc_cache2w.sv
module wtc_cache2w
   import wtc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IDX_W    = 6,
   parameter int unsigned WB_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_done,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   input  logic              mem_wr_ack
);
   localparam int unsigned TAG_W    = ADDR_W - IDX_W;
   localparam int unsigned WB_CNT_W = $clog2(WB_DEPTH) + 1;

   if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_index
      $error("wtc_cache2w: IDX_W must lie in 1 .. ADDR_W-1");
   end
   if (WB_DEPTH < 2 || (WB_DEPTH & (WB_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wtc_cache2w: WB_DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("wtc_cache2w: DATA_W must be positive");
   end

   logic [IDX_W-1:0]  set_idx;
   logic [TAG_W-1:0]  set_tag;
   logic [WTC_WAYS-1:0] way_hit, upd_en, fill_en;
   logic [DATA_W-1:0] way_word [WTC_WAYS];
   logic              lookup_hit, hit_way, victim;
   logic              touch_en, touch_way;
   logic              wb_push, wb_full, wb_busy;
   logic [WB_CNT_W-1:0] wb_cnt;
   wtc_ctl_t          state_q, state_d;

   assign set_idx = cpu_addr[IDX_W-1:0];
   assign set_tag = cpu_addr[ADDR_W-1:IDX_W];

   for (genvar w = 0; w < WTC_WAYS; w++) begin : g_way
      wtc_way #(
         .IDX_W (IDX_W),
         .TAG_W (TAG_W),
         .DATA_W(DATA_W)
      ) u_way (
         .clk      (clk),
         .rst_n    (rst_n),
         .idx      (set_idx),
         .tag      (set_tag),
         .hit      (way_hit[w]),
         .rd_data  (way_word[w]),
         .upd_en   (upd_en[w]),
         .upd_data (cpu_wdata),
         .fill_en  (fill_en[w]),
         .fill_data(mem_rd_data)
      );
   end

   assign lookup_hit = |way_hit;
   assign hit_way    = way_hit[1];
   assign cpu_rdata  = way_hit[1] ? way_word[1] : way_word[0];

   wtc_lru #(.IDX_W(IDX_W)) u_lru (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (set_idx),
      .touch_en (touch_en),
      .touch_way(touch_way),
      .victim   (victim)
   );

   wtc_wbuf #(
      .AW   (ADDR_W),
      .DW   (DATA_W),
      .DEPTH(WB_DEPTH)
   ) u_wbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (wb_push),
      .push_addr(cpu_addr),
      .push_data(cpu_wdata),
      .full     (wb_full),
      .busy     (wb_busy),
      .head_addr(mem_wr_addr),
      .head_data(mem_wr_data),
      .pop      (mem_wr_ack),
      .fill_cnt (wb_cnt)
   );

   assign mem_wr_req  = wb_busy;
   assign mem_rd_addr = cpu_addr;

   always_comb begin
      state_d    = state_q;
      cpu_done   = 1'b0;
      wb_push    = 1'b0;
      upd_en     = '0;
      fill_en    = '0;
      touch_en   = 1'b0;
      touch_way  = 1'b0;
      mem_rd_req = 1'b0;
      case (state_q)
         CTL_IDLE: begin
            if (cpu_req) begin
               if (cpu_we) begin
                  if (!wb_full) begin
                     cpu_done = 1'b1;
                     wb_push  = 1'b1;
                     if (lookup_hit) begin
                        upd_en[hit_way] = 1'b1;
                        touch_en        = 1'b1;
                        touch_way       = hit_way;
                     end
                  end
               end else if (lookup_hit) begin
                  cpu_done  = 1'b1;
                  touch_en  = 1'b1;
                  touch_way = hit_way;
               end else begin
                  state_d = wb_busy ? CTL_DRAIN : CTL_FILL;
               end
            end
         end
         CTL_DRAIN: begin
            if (!wb_busy) state_d = CTL_FILL;
         end
         CTL_FILL: begin
            mem_rd_req = 1'b1;
            if (mem_rd_valid) begin
               fill_en[victim] = 1'b1;
               touch_en        = 1'b1;
               touch_way       = victim;
               state_d         = CTL_IDLE;
            end
         end
         default: state_d = CTL_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= CTL_IDLE;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/wtc_cache2w_chk.sv
module wtc_cache2w_chk #(
   parameter int unsigned WB_DEPTH = 4,
   parameter int unsigned CNT_W    = 3,
   parameter int unsigned ADDR_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic              cpu_done,
   input logic              lookup_hit,
   input logic              mem_rd_req,
   input logic              mem_rd_valid,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_wr_req,
   input logic [CNT_W-1:0]  wb_cnt
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WB_DEPTH);

   AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> cpu_req); // R10
   AST_READ_DONE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && !cpu_we) |-> lookup_hit); // R2
   AST_NO_FILL_OVER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !mem_wr_req); // R9
   AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && wb_cnt == CNT_FULL) |-> !cpu_done); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wb_cnt <= CNT_FULL); // R8
   AST_STORE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && cpu_we) |=> mem_wr_req); // R5
   AST_FILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr))); // R3
endmodule

bind wtc_cache2w wtc_cache2w_chk #(
   .WB_DEPTH(WB_DEPTH),
   .CNT_W   (WB_CNT_W),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cpu_req     (cpu_req),
   .cpu_we      (cpu_we),
   .cpu_done    (cpu_done),
   .lookup_hit  (lookup_hit),
   .mem_rd_req  (mem_rd_req),
   .mem_rd_valid(mem_rd_valid),
   .mem_rd_addr (mem_rd_addr),
   .mem_wr_req  (mem_wr_req),
   .wb_cnt      (wb_cnt)
);

// File: tb/tb_wtc_cache2w.sv
module tb_wtc_cache2w;
   localparam int AW  = 6;
   localparam int DW  = 32;
   localparam int IW  = 2;
   localparam int WBD = 4;
   localparam int NW  = 1 << AW;
   localparam int NS  = 1 << IW;
   localparam int RD_LAT = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          cpu_done;
   logic          mem_rd_req;
   logic [AW-1:0] mem_rd_addr;
   logic          mem_rd_valid = 1'b0;
   logic [DW-1:0] mem_rd_data = '0;
   logic          mem_wr_req;
   logic [AW-1:0] mem_wr_addr;
   logic [DW-1:0] mem_wr_data;
   logic          mem_wr_ack = 1'b0;

   always #5 clk = ~clk;

   wtc_cache2w #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .WB_DEPTH(WBD)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_wr_ack(mem_wr_ack)
   );

   int n_chk = 0, n_fail = 0;
   logic [DW-1:0] mem_arr [NW];
   logic [DW-1:0] gold    [NW];
   logic [AW-1:0] eq_a [64];
   logic [DW-1:0] eq_d [64];
   int  eq_wr = 0, eq_rd = 0;
   bit  ack_en = 1'b1;
   int  rd_cnt = 0;
   bit  m_vld [NS][2];
   logic [AW-IW-1:0] m_tag [NS][2];
   bit  m_old [NS];

   function automatic logic [DW-1:0] init_val(int a);
      return 32'hC0DE_0000 + DW'(a * 13);
   endfunction

   task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // memory model: refill after RD_LAT cycles, store acceptance gated by ack_en
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd_valid) begin
            mem_rd_valid <= 1'b0;
            rd_cnt <= 0;
         end else if (mem_rd_req) begin
            if (rd_cnt == RD_LAT - 1) begin
               mem_rd_valid <= 1'b1;
               mem_rd_data  <= mem_arr[mem_rd_addr];
            end else rd_cnt <= rd_cnt + 1;
         end
         mem_wr_ack <= ack_en && mem_wr_req;
         if (ack_en && mem_wr_req) begin
            mem_arr[mem_wr_addr] <= mem_wr_data;
            chk(eq_rd < eq_wr, "R5", "unexpected store on memory port", DW'(eq_wr - eq_rd), 32'd1);
            chk(mem_wr_addr == eq_a[eq_rd % 64], "R5", "store order address",
                DW'(mem_wr_addr), DW'(eq_a[eq_rd % 64]));
            chk(mem_wr_data == eq_d[eq_rd % 64], "R5", "store order data",
                mem_wr_data, eq_d[eq_rd % 64]);
            eq_rd++;
         end
      end
   end

   function automatic bit m_lookup(logic [AW-1:0] a, output bit way);
      int s = int'(a[IW-1:0]);
      bit h0 = m_vld[s][0] && m_tag[s][0] == a[AW-1:IW];
      bit h1 = m_vld[s][1] && m_tag[s][1] == a[AW-1:IW];
      way = h1;
      return h0 || h1;
   endfunction

   task automatic m_update(bit we, logic [AW-1:0] a);
      int s = int'(a[IW-1:0]);
      bit w;
      if (m_lookup(a, w)) m_old[s] = ~w;
      else if (!we) begin
         w = m_old[s];
         m_vld[s][w] = 1'b1;
         m_tag[s][w] = a[AW-1:IW];
         m_old[s] = ~w;
      end
   endtask

   task automatic note_store(logic [AW-1:0] a, logic [DW-1:0] d);
      eq_a[eq_wr % 64] = a;
      eq_d[eq_wr % 64] = d;
      eq_wr++;
      gold[a] = d;
   endtask

   task automatic wait_done(inout bit missed);
      forever begin
         #1;
         if (mem_rd_req) missed = 1'b1;
         if (cpu_done) break;
         @(negedge clk);
      end
   endtask

   task automatic finish_access();
      @(posedge clk);
      #1;
      cpu_req = 1'b0;
   endtask

   // one access checked against the model; returns whether memory was read
   task automatic op(bit we, logic [AW-1:0] a, logic [DW-1:0] wd, string rq, output bit missed);
      bit w;
      bit exp_hit = m_lookup(a, w);
      logic [DW-1:0] exp_d = gold[a];
      missed = 1'b0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      wait_done(missed);
      if (we) begin
         note_store(a, wd);
         chk(!missed, rq, "store read memory", DW'(missed), 32'd0);
      end else begin
         chk(cpu_rdata == exp_d, rq, "read data", cpu_rdata, exp_d);
         chk(missed == !exp_hit, rq, "miss flag", DW'(missed), DW'(!exp_hit));
      end
      m_update(we, a);
      finish_access();
   endtask

   task automatic drain();
      ack_en = 1'b1;
      while (mem_wr_req || mem_wr_ack) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      bit ms;
      for (int a = 0; a < NW; a++) begin
         mem_arr[a] = init_val(a);
         gold[a]    = init_val(a);
      end
      for (int s = 0; s < NS; s++) begin
         m_old[s] = 1'b0;
         for (int w = 0; w < 2; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = '0; end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(cpu_done == 1'b0, "R1", "done after reset", DW'(cpu_done), 32'd0);
      chk(mem_rd_req == 1'b0, "R1", "refill after reset", DW'(mem_rd_req), 32'd0);
      chk(mem_wr_req == 1'b0, "R1", "queue after reset", DW'(mem_wr_req), 32'd0);
      chk(cpu_done == 1'b0, "R10", "done without request", DW'(cpu_done), 32'd0);

      // R1 R3: every address read once from cold, each must miss
      for (int a = 0; a < NW; a++) begin
         op(1'b0, AW'(a), '0, "R3", ms);
         chk(ms == 1'b1, "R1", "cold read must miss", DW'(ms), 32'd1);
      end
      // R2: last two tags of each set are resident
      op(1'b0, 6'h3D, '0, "R2", ms);
      chk(ms == 1'b0, "R2", "resident read hit", DW'(ms), 32'd0);
      op(1'b0, 6'h39, '0, "R2", ms);
      chk(ms == 1'b0, "R2", "resident read hit other way", DW'(ms), 32'd0);

      // R4: replacement order in set 3
      op(1'b0, 6'h03, '0, "R4", ms);
      chk(ms, "R4", "0x03 miss", DW'(ms), 32'd1);
      op(1'b0, 6'h07, '0, "R4", ms);
      chk(ms, "R4", "0x07 miss", DW'(ms), 32'd1);
      op(1'b0, 6'h03, '0, "R4", ms);
      chk(!ms, "R4", "0x03 hit", DW'(ms), 32'd0);
      op(1'b0, 6'h0B, '0, "R4", ms);
      chk(ms, "R4", "0x0B miss", DW'(ms), 32'd1);
      op(1'b0, 6'h03, '0, "R4", ms);
      chk(!ms, "R4", "0x03 kept", DW'(ms), 32'd0);
      op(1'b0, 6'h07, '0, "R4", ms);
      chk(ms, "R4", "0x07 evicted", DW'(ms), 32'd1);

      // R6: store hit updates the line
      op(1'b1, 6'h07, 32'h1234_5678, "R6", ms);
      op(1'b0, 6'h07, '0, "R6", ms);
      chk(!ms, "R6", "read after store hit", DW'(ms), 32'd0);

      // R7: store miss does not allocate
      op(1'b1, 6'h1E, 32'h0BAD_F00D, "R7", ms);
      op(1'b0, 6'h1E, '0, "R7", ms);
      chk(ms, "R7", "read after store miss", DW'(ms), 32'd1);

      // R8: full queue stalls a store
      drain();
      ack_en = 1'b0;
      for (int k = 0; k < WBD; k++) op(1'b1, AW'(32 + k), DW'(32'h5500_0000 + k), "R8", ms);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 6'h24; cpu_wdata = 32'h5500_00FF;
      for (int k = 0; k < 6; k++) begin
         #1;
         chk(cpu_done == 1'b0, "R8", "store done while queue full", DW'(cpu_done), 32'd0);
         @(negedge clk);
      end
      ack_en = 1'b1;
      ms = 1'b0;
      wait_done(ms);
      note_store(6'h24, 32'h5500_00FF);
      m_update(1'b1, 6'h24);
      finish_access();
      chk(1'b1, "R8", "stalled store completed", 32'd1, 32'd1);

      // R9: read miss waits for pending stores, then sees them
      drain();
      ack_en = 1'b0;
      op(1'b1, 6'h10, 32'hAAAA_0010, "R9", ms);
      op(1'b1, 6'h11, 32'hAAAA_0011, "R9", ms);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 6'h11;
      for (int k = 0; k < 5; k++) begin
         #1;
         chk(mem_rd_req == 1'b0, "R9", "refill while stores pending", DW'(mem_rd_req), 32'd0);
         chk(cpu_done == 1'b0, "R10", "miss done early", DW'(cpu_done), 32'd0);
         @(negedge clk);
      end
      ack_en = 1'b1;
      ms = 1'b0;
      wait_done(ms);
      chk(cpu_rdata == 32'hAAAA_0011, "R9", "read sees pending store", cpu_rdata, 32'hAAAA_0011);
      chk(ms, "R9", "miss fetched memory", DW'(ms), 32'd1);
      m_update(1'b0, 6'h11);
      finish_access();

      // R2 R4 R6: mixed sweep against the model
      for (int i = 0; i < 320; i++) begin
         logic [AW-1:0] a = AW'(i * 23 + (i >> 3));
         op((i % 5) == 2, a, DW'(i) * 32'h0101_0101 ^ 32'hA5A5_5A5A, "R4", ms);
      end

      // R5: memory holds every store after draining
      drain();
      chk(eq_rd == eq_wr, "R5", "stores delivered", DW'(eq_rd), DW'(eq_wr));
      for (int a = 0; a < NW; a++)
         chk(mem_arr[a] == gold[a], "R5", "memory image", mem_arr[a], gold[a]);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule